// File: doc/BRIEF.md
# Sort-then-Route Packet Switch

This block is an eight-port packet switch that delivers one batch of packets per clock cycle. Every input lane presents a valid flag, a destination port number and a payload byte. The switch works in two steps. First, a bitonic sorting network puts the batch in ascending destination order. Second, a shuffle-exchange (Omega-type) banyan fabric sends each sorted packet to its output port, steering by the destination bits from the most significant bit down.

A banyan fabric has no internal collisions only when its inputs meet two conditions: they are ordered by destination, and they are packed with no gaps. The sorter alone provides the ordering. A short dedup step between the two parts provides the packing. It removes all but the first packet of any group that targets the same port, and it closes the gaps left by the removed packets. Each such port is flagged so the surrounding logic can see that traffic was discarded.

The sorter places a register after every `SORT_PIPE` compare-exchange stages and always after the last stage. The output ports are also registered. Latency is therefore fixed: ceil(6/`SORT_PIPE`)+1 cycles, which is 4 cycles with the default of 2.

Top module: `bb_switch`

## Requirements
- R1: Reset is synchronous and active-low. After a clock edge with `rst_n` low, all pipeline stages hold idle entries and `out_valid`, `out_dup` and `out_data` read zero.
- R2: A batch sampled at clock edge t appears on the outputs just after edge t+3 (default parameters) and holds for exactly one cycle. A new batch may enter on every edge.
- R3: Input lane i carries its destination in `in_dest[3i+2:3i]` and its payload in `in_data[8i+7:8i]`. A valid packet whose destination d is unique in its batch leaves with `out_valid[d]`=1 and `out_data[8d+7:8d]` equal to its payload. A port that receives nothing shows `out_valid`=0 and a zero payload.
- R4: Any set of distinct destinations is delivered in full, whether it is a full permutation or a partial one. No 2x2 element in the banyan fabric ever has two valid packets requesting the same output.
- R5: A lane with `in_valid`=0 has no effect on any output, whatever its destination and payload bits hold.
- R6: When several valid packets in one batch target the same port, exactly one is delivered: the packet from the lowest-numbered input lane.
- R7: `out_dup[d]` is 1 in the same output cycle as the batch exactly when two or more valid packets of that batch targeted d. Whenever it is 1, `out_valid[d]` is 1 as well.
- R8: Packets with unique destinations are delivered intact even when the same batch contains duplicate groups.
- R9: The sorter output is in ascending order of the key {idle flag, destination, input lane}, so idle entries collect at the highest positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 8 | Per-lane packet present flag |
| in_dest | input | 24 | Per-lane destination port, 3 bits per lane |
| in_data | input | 64 | Per-lane payload, 8 bits per lane |
| out_valid | output | 8 | Per-port packet delivered flag |
| out_data | output | 64 | Per-port payload, 8 bits per port, zero when idle |
| out_dup | output | 8 | Per-port flag: two or more packets targeted this port |

## Verification
Several structural properties are checked by assertions on every cycle:
- The sorter output is ordered.
- The dedup output is packed and strictly increasing in destination.
- No banyan element sees a collision.
- Each packet leaving the fabric sits at the port equal to its destination.
- A duplicate flag never appears without a delivered packet on that port.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs against a scoreboard:
- the fixed latency;
- payload integrity;
- the lowest-lane winner among duplicates;
- whether idle lanes are ignored;
- the reset state.

The scenarios cover identity, reversal, bit-reversal, the worked sort example, partial batches, duplicate-heavy batches and long runs of random back-to-back batches.

// File: rtl/bb_pkg.sv
// Package: shared elaboration-time helpers for the sort-then-route switch.
// Assumes the port count is a power of two; lg is its base-2 logarithm.
package bb_pkg;

    // Block size of bitonic stage s (2, 4, 4, 8, 8, 8 for lg=3).
    function automatic int stage_blk(input int lg, input int s);
        int idx;
        int res;
        idx = 0;
        res = 0;
        for (int b = 1; b <= lg; b++) begin
            for (int j = b - 1; j >= 0; j--) begin
                if (idx == s) res = 1 << b;
                idx++;
            end
        end
        return res;
    endfunction

    // Partner distance of bitonic stage s (1, 2, 1, 4, 2, 1 for lg=3).
    function automatic int stage_dist(input int lg, input int s);
        int idx;
        int res;
        idx = 0;
        res = 0;
        for (int b = 1; b <= lg; b++) begin
            for (int j = b - 1; j >= 0; j--) begin
                if (idx == s) res = 1 << j;
                idx++;
            end
        end
        return res;
    endfunction

    // Perfect-shuffle position: rotate an lg-bit index left by one.
    function automatic int rotl(input int p, input int lg);
        return ((p << 1) | (p >> (lg - 1))) & ((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/bb_cmpx.sv
// Compare-exchange element: orders two entries by their top KW key bits.
// ASCEND=1 puts the smaller key on lo_o; ASCEND=0 puts it on hi_o.
// Assumes the key occupies the most significant KW bits of each entry.
module bb_cmpx #(
    parameter int EW     = 15,
    parameter int KW     = 7,
    parameter bit ASCEND = 1'b1
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] lo_o,
    output logic [EW-1:0] hi_o
);
    logic swap;

    // Swap when the pair is out of the requested order.
    always_comb begin
        swap = ASCEND ? (a_i[EW-1 -: KW] > b_i[EW-1 -: KW])
                      : (a_i[EW-1 -: KW] < b_i[EW-1 -: KW]);
        lo_o = swap ? b_i : a_i;
        hi_o = swap ? a_i : b_i;
    end
endmodule

// File: rtl/bb_sorter.sv
// Bitonic sorting network for N entries (N a power of two).
// Registers follow every PIPE stages and always the final stage.
// Assumes the key is the top KW bits of each entry; IDLE is the reset value.
module bb_sorter #(
    parameter int N    = 8,
    parameter int EW   = 15,
    parameter int KW   = 7,
    parameter int PIPE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] row_i [N],
    output logic [EW-1:0] row_o [N]
);
    localparam int L = $clog2(N);
    localparam int S = L * (L + 1) / 2;
    localparam logic [EW-1:0] IDLE = {1'b1, {(EW-1){1'b0}}};

    for (genvar s = 0; s < S; s++) begin : g_stg
        localparam int BK = bb_pkg::stage_blk(L, s);
        localparam int DJ = bb_pkg::stage_dist(L, s);
        logic [EW-1:0] din  [N];
        logic [EW-1:0] cx   [N];
        logic [EW-1:0] dout [N];

        if (s == 0) begin : g_head
            assign din = row_i;
        end else begin : g_link
            assign din = g_stg[s-1].dout;
        end

        for (genvar i = 0; i < N; i++) begin : g_el
            if ((i & DJ) == 0) begin : g_pair
                bb_cmpx #(.EW(EW), .KW(KW), .ASCEND((i & BK) == 0)) u_cx (
                    .a_i (din[i]),
                    .b_i (din[i+DJ]),
                    .lo_o(cx[i]),
                    .hi_o(cx[i+DJ])
                );
            end
        end

        if (((s + 1) % PIPE) == 0 || s == S - 1) begin : g_reg
            // Pipeline register for this stage group.
            always_ff @(posedge clk) begin
                for (int i = 0; i < N; i++)
                    dout[i] <= !rst_n ? IDLE : cx[i];
            end
        end else begin : g_wire
            assign dout = cx;
        end
    end

    assign row_o = g_stg[S-1].dout;

    for (genvar i = 1; i < N; i++) begin : g_chk
        assert_sorted_R9: assert property (@(posedge clk) disable iff (!rst_n)
            row_o[i-1][EW-1 -: KW] <= row_o[i][EW-1 -: KW]);
    end
endmodule

// File: rtl/bb_dedup.sv
// Dedup and pack: keeps the first entry of each equal-destination run in
// the sorted row, flags the shared port, and packs survivors to the top.
// Assumes input sorted by {idle, dest, lane}, so duplicates are adjacent.
module bb_dedup #(
    parameter int N  = 8,
    parameter int DW = 3,
    parameter int SW = 3,
    parameter int PW = 8
) (
    input  logic [1+DW+SW+PW-1:0] row_i [N],
    output logic [1+DW+SW+PW-1:0] row_o [N],
    output logic [N-1:0]          dup_o
);
    localparam int EW = 1 + DW + SW + PW;
    localparam logic [EW-1:0] IDLE = {1'b1, {(EW-1){1'b0}}};

    // Detect repeats, mark their port, and compact survivors by rank.
    always_comb begin
        logic [DW-1:0] rank;
        logic          cur_v;
        logic          same;
        rank  = '0;
        dup_o = '0;
        for (int i = 0; i < N; i++) row_o[i] = IDLE;
        for (int i = 0; i < N; i++) begin
            cur_v = !row_i[i][EW-1];
            same  = 1'b0;
            if (i > 0)
                same = cur_v && !row_i[i-1][EW-1] &&
                       (row_i[i-1][PW+SW +: DW] == row_i[i][PW+SW +: DW]);
            if (same) dup_o[row_i[i][PW+SW +: DW]] = 1'b1;
            if (cur_v && !same) begin
                row_o[rank] = row_i[i];
                rank = rank + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bb_omega.sv
// Omega banyan fabric: log2(N) levels of perfect shuffle followed by 2x2
// elements steered by destination bits, most significant first (0 = upper).
// Assumes packed, destination-ordered input; reports any element collision.
module bb_omega #(
    parameter int N  = 8,
    parameter int DW = 3,
    parameter int SW = 3,
    parameter int PW = 8
) (
    input  logic [1+DW+SW+PW-1:0] row_i [N],
    output logic [1+DW+SW+PW-1:0] row_o [N],
    output logic [DW*N/2-1:0]     clash_o
);
    localparam int EW = 1 + DW + SW + PW;
    localparam int H  = N / 2;
    localparam logic [EW-1:0] IDLE = {1'b1, {(EW-1){1'b0}}};

    for (genvar k = 0; k < DW; k++) begin : g_lvl
        logic [EW-1:0] pv [N];
        logic [EW-1:0] sh [N];
        logic [EW-1:0] lv [N];

        if (k == 0) begin : g_head
            assign pv = row_i;
        end else begin : g_link
            assign pv = g_lvl[k-1].lv;
        end

        for (genvar p = 0; p < N; p++) begin : g_shuf
            assign sh[bb_pkg::rotl(p, DW)] = pv[p];
        end

        for (genvar m = 0; m < H; m++) begin : g_sw
            logic va, vb, ra, rb;
            assign va = !sh[2*m][EW-1];
            assign vb = !sh[2*m+1][EW-1];
            assign ra = sh[2*m][PW+SW+DW-1-k];
            assign rb = sh[2*m+1][PW+SW+DW-1-k];
            assign lv[2*m]   = (va && !ra) ? sh[2*m] : ((vb && !rb) ? sh[2*m+1] : IDLE);
            assign lv[2*m+1] = (va &&  ra) ? sh[2*m] : ((vb &&  rb) ? sh[2*m+1] : IDLE);
            assign clash_o[k*H+m] = va && vb && (ra == rb);
        end
    end

    assign row_o = g_lvl[DW-1].lv;
endmodule

// File: rtl/bb_switch.sv
// Sort-then-route switch top: packs lanes into keyed entries, sorts them,
// removes duplicates, routes through the banyan fabric, registers outputs.
// Assumes N is a power of two; latency is LATENCY cycles, fixed.
module bb_switch #(
    parameter int N         = 8,
    parameter int PW        = 8,
    parameter int SORT_PIPE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               in_valid,
    input  logic [N*$clog2(N)-1:0]     in_dest,
    input  logic [N*PW-1:0]            in_data,
    output logic [N-1:0]               out_valid,
    output logic [N*PW-1:0]            out_data,
    output logic [N-1:0]               out_dup
);
    localparam int DW        = $clog2(N);
    localparam int SW        = DW;
    localparam int KW        = 1 + DW + SW;
    localparam int EW        = KW + PW;
    localparam int STAGES    = DW * (DW + 1) / 2;
    localparam int SORT_REGS = (STAGES + SORT_PIPE - 1) / SORT_PIPE;
    localparam int LATENCY   = SORT_REGS + 1;

    logic [EW-1:0]        lane_row [N];
    logic [EW-1:0]        sort_row [N];
    logic [EW-1:0]        pack_row [N];
    logic [EW-1:0]        fab_row  [N];
    logic [N-1:0]         dup_port;
    logic [DW*N/2-1:0]    clash;

    // Build keyed entries; idle lanes get a cleared destination.
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lane_row[i] = {!in_valid[i],
                              in_valid[i] ? in_dest[i*DW +: DW] : {DW{1'b0}},
                              SW'(i),
                              in_data[i*PW +: PW]};
    end

    bb_sorter #(.N(N), .EW(EW), .KW(KW), .PIPE(SORT_PIPE)) u_sort (
        .clk  (clk),
        .rst_n(rst_n),
        .row_i(lane_row),
        .row_o(sort_row)
    );

    bb_dedup #(.N(N), .DW(DW), .SW(SW), .PW(PW)) u_dedup (
        .row_i(sort_row),
        .row_o(pack_row),
        .dup_o(dup_port)
    );

    bb_omega #(.N(N), .DW(DW), .SW(SW), .PW(PW)) u_fab (
        .row_i  (pack_row),
        .row_o  (fab_row),
        .clash_o(clash)
    );

    // Output register: per-port valid, masked payload and duplicate flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            out_dup   <= '0;
        end else begin
            for (int p = 0; p < N; p++) begin
                out_valid[p]         <= !fab_row[p][EW-1];
                out_data[p*PW +: PW] <= fab_row[p][EW-1] ? {PW{1'b0}} : fab_row[p][PW-1:0];
            end
            out_dup <= dup_port;
        end
    end

    assert_no_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clash == '0);

    for (genvar p = 0; p < N; p++) begin : g_chk_port
        assert_port_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !fab_row[p][EW-1] |-> (fab_row[p][PW+SW +: DW] == DW'(p)));
        assert_dup_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_dup[p] |-> out_valid[p]);
    end

    for (genvar i = 1; i < N; i++) begin : g_chk_pack
        assert_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !pack_row[i][EW-1] |-> (!pack_row[i-1][EW-1] &&
             (pack_row[i-1][PW+SW +: DW] < pack_row[i][PW+SW +: DW])));
    end
endmodule

// File: tb/bb_switch_tb.sv
// Scoreboard bench: the driver pushes the expected per-port result of each
// batch, and the monitor pops and compares it when the result is due.
module bb_switch_tb;
    localparam int N = 8;
    localparam int DW = 3;
    localparam int PW = 8;
    localparam int LAT = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*DW-1:0] in_dest  = '0;
    logic [N*PW-1:0] in_data  = '0;
    logic [N-1:0]    out_valid;
    logic [N*PW-1:0] out_data;
    logic [N-1:0]    out_dup;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    int              q_tgt [$];
    string           q_tag [$];
    logic [N-1:0]    q_v   [$];
    logic [N*PW-1:0] q_d   [$];
    logic [N-1:0]    q_u   [$];

    bb_switch u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_dup(out_dup)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [N*DW-1:0] pk(input int a [N]);
        logic [N*DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'(a[i]);
        return r;
    endfunction

    function automatic logic [N*PW-1:0] mkdata(input int seed);
        logic [N*PW-1:0] r;
        for (int i = 0; i < N; i++) r[i*PW +: PW] = PW'(seed + 37 * i + 1);
        return r;
    endfunction

    // Driver: applies one batch and records its expected port results.
    task automatic send(input logic [N-1:0] v, input logic [N*DW-1:0] d,
                        input logic [N*PW-1:0] x, input string tag);
        logic [N-1:0]    ev;
        logic [N*PW-1:0] ed;
        logic [N-1:0]    eu;
        @(negedge clk);
        in_valid = v;
        in_dest  = d;
        in_data  = x;
        ev = '0; ed = '0; eu = '0;
        for (int p = 0; p < N; p++) begin
            int cnt = 0;
            for (int i = 0; i < N; i++) begin
                if (v[i] && d[i*DW +: DW] == DW'(p)) begin
                    if (cnt == 0) begin
                        ev[p] = 1'b1;
                        ed[p*PW +: PW] = x[i*PW +: PW];
                    end
                    cnt++;
                end
            end
            eu[p] = (cnt >= 2);
        end
        q_tgt.push_back(cyc + LAT);
        q_tag.push_back(tag);
        q_v.push_back(ev);
        q_d.push_back(ed);
        q_u.push_back(eu);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send('0, '1, '1, "R5 idle/R2 latency");
    endtask

    // Monitor: compares outputs with the due scoreboard entry.
    always @(negedge clk) begin
        if (q_tgt.size() > 0 && q_tgt[0] == cyc) begin
            n_chk++;
            if (out_valid !== q_v[0] || out_data !== q_d[0] || out_dup !== q_u[0]) begin
                n_bad++;
                $display("FAIL %s: got v=%h d=%h dup=%h exp v=%h d=%h dup=%h",
                         q_tag[0], out_valid, out_data, out_dup, q_v[0], q_d[0], q_u[0]);
            end
            void'(q_tgt.pop_front()); void'(q_tag.pop_front());
            void'(q_v.pop_front()); void'(q_d.pop_front()); void'(q_u.pop_front());
        end
    end

    task automatic check_reset(input string tag);
        n_chk++;
        if (out_valid !== '0 || out_data !== '0 || out_dup !== '0) begin
            n_bad++;
            $display("FAIL %s: got v=%h d=%h dup=%h exp all zero", tag, out_valid, out_data, out_dup);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        finish_run();
    end

    initial begin : main
        int rev [N];
        int brv [N];
        int idn [N];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R1 reset");
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            idn[i] = i;
            rev[i] = N - 1 - i;
            brv[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
        end

        idle(2);
        send('1, pk(idn), mkdata(3), "R3 identity");
        send('1, pk(rev), mkdata(50), "R4 reversal");
        send('1, pk(brv), mkdata(90), "R4 bit-reversal");
        send('1, pk('{5,7,0,4,2,1,3,6}), mkdata(120), "R4 worked sort example");
        send(8'b1010_0101, pk('{6,7,1,0,3,2,4,5}), mkdata(7), "R5 partial batch");
        send(8'b0000_0000, pk('{2,2,2,2,2,2,2,2}), mkdata(9), "R5 all idle");
        send(8'b0001_0000, pk('{0,0,0,0,7,0,0,0}), mkdata(11), "R3 single packet");
        idle(5);
        send('1, pk('{3,3,3,3,3,3,3,3}), mkdata(200), "R6 R7 all to one port");
        send('1, pk('{1,4,1,6,0,4,2,1}), mkdata(33), "R8 mixed duplicates");
        send(8'b1100_1010, pk('{5,5,5,2,5,5,2,0}), mkdata(61), "R6 winner lowest lane");

        // Mid-run synchronous reset with batches in flight.
        send('1, pk(rev), mkdata(70), "R1 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = '1;
        q_tgt.delete(); q_tag.delete(); q_v.delete(); q_d.delete(); q_u.delete();
        @(negedge clk);
        check_reset("R1 mid-run reset");
        rst_n = 1'b1;
        in_valid = '0;
        idle(4);

        // Back-to-back random batches, duplicates included.
        for (int t = 0; t < 400; t++) begin
            int pa [N];
            for (int i = 0; i < N; i++) pa[i] = i;
            for (int i = N - 1; i > 0; i--) begin
                int j = $urandom_range(i, 0);
                int tmp = pa[i];
                pa[i] = pa[j];
                pa[j] = tmp;
            end
            if (t % 2 == 0)
                send(N'($urandom), pk(pa), N*PW'({$urandom, $urandom}), "R2 R4 random distinct");
            else
                send(N'($urandom), N*DW'($urandom), N*PW'({$urandom, $urandom}), "R8 random any");
        end
        idle(LAT + 2);
        while (q_tgt.size() > 0) @(negedge clk);
        finish_run();
    end
endmodule